// File: doc/BRIEF.md
# Cross-Domain Register Write Tracker

This block sits between a fast bus and a bank of registers clocked by a separate, slower and unrelated clock. A write to a remote register is captured on the bus side and passed to the slow side with a toggle handshake. Each direction of the handshake goes through a two-flop synchronizer. While the transfer is in flight, a write-complete flag reads as zero. Software polls that flag, or waits for the completion interrupt, before it starts the next access. The flag returns to one only after the slow side has performed the write and its acknowledge has crossed back.

The address's top bit separates remote registers from the block's own local registers. Local registers are reached at addresses with the top bit set, and `addr[1:0]` selects one of them:

- offset 0 is the status register: bit 0 is write-complete and bit 1 is the busy-write error. It is read-only.
- offset 1 is the interrupt mask, held in bit 0.
- offset 2 reads the raw interrupt in bit 0. Writing to it clears bits: a one in bit 0 clears the raw interrupt and a one in bit 1 clears the error.
- offset 3 reads the masked interrupt in bit 0.

Reads never enter the handshake. A read of a remote address samples the slow bank's read data, which the bank presents combinationally from `rmt_rd_addr`.

The write channel uses `wr_valid` and `wr_ready`, and `wr_ready` is held high. The block never applies back-pressure. A remote write offered while a transfer is in flight is consumed and discarded, and it sets a sticky error flag. The read channel has no back-pressure either. Every `rd_valid` cycle is answered one cycle later with `rd_data_valid`.

Top module: `xwt_tracker`

## Requirements
- R1: After reset, write-complete is 1, the error flag is 0, the raw interrupt is 0, the mask is 0, `irq` is 0 and `wr_ready` is 1.
- R2: A remote write (`wr_addr[7]`=0) offered while write-complete is 1 is accepted. From the next bus cycle, write-complete reads 0 in bit 0 of the status register (local offset 0).
- R3: Each accepted remote write produces exactly one `slow_wr_en` pulse, one slow cycle wide. During that pulse `slow_wr_addr` and `slow_wr_data` equal the written values, and both stay stable until write-complete returns to 1.
- R4: Write-complete returns to 1 only after the slow side's acknowledge has crossed back. In that same bus cycle the raw interrupt (bit 0 of local offset 2) is set.
- R5: `irq` and bit 0 of local offset 3 equal the raw interrupt ANDed with the mask, where the mask is bit 0 of local offset 1.
- R6: Writing local offset 2 with bit 0 set clears the raw interrupt, and with bit 1 set clears the error flag. Zero bits in that write have no effect.
- R7: A remote write offered while write-complete is 0 is dropped. It produces no `slow_wr_en` pulse, leaves write-complete at 0, and sets the sticky error flag (bit 1 of local offset 0).
- R8: Every `rd_valid` cycle returns `rd_data_valid` on the next cycle, including while a transfer is in flight. A remote read returns `rmt_rd_data` for `rmt_rd_addr` = `rd_addr`.
- R9: Local register writes are accepted while a transfer is in flight, and they do not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write consumed (held high) |
| wr_addr | input | 8 | Write address; bit 7 selects local registers |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 8 | Read address; bit 7 selects local registers |
| rd_data_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Masked write-complete interrupt |
| rmt_rd_addr | output | 8 | Read address presented to the slow register bank |
| rmt_rd_data | input | 32 | Read data from the slow register bank |
| slow_clk | input | 1 | Slow-domain clock |
| slow_rst_n | input | 1 | Slow-side active-low reset |
| slow_wr_en | output | 1 | One-slow-cycle write strobe to the slow register bank |
| slow_wr_addr | output | 8 | Held write address for the slow bank |
| slow_wr_data | output | 32 | Held write data for the slow bank |

## Verification
The bench targets these corner cases, and for each one names what a faulty design would show:

- A remote write issued while busy. A faulty design would launch a second slow strobe, change the held address, or leave the error flag clear.
- Clearing by writing with zero bits and with individual bits. A faulty design would clear the wrong flag or clear on any write.
- Reads during a transfer. A design that stalled them would drop `rd_data_valid`.
- A mask change made while busy. Such a design would lose or corrupt the write in flight.
- Write-complete rising early, before the slow strobe. This would show up as a slow-side count that lags behind completion.

// File: rtl/xwt_pkg.sv
package xwt_pkg;
  typedef enum logic [1:0] {
    LR_STATUS = 2'd0,
    LR_MASK   = 2'd1,
    LR_RAW    = 2'd2,
    LR_MASKED = 2'd3
  } loc_reg_e;

  localparam int ST_DONE_BIT = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int CLR_RAW_BIT = 0;
  localparam int CLR_ERR_BIT = 1;
  localparam int MASK_BIT    = 0;
endpackage

// File: rtl/xwt_sync.sv
module xwt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xwt_wr_ctrl.sv
module xwt_wr_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_sync,
  output logic              req_tgl,
  output logic              wr_done,
  output logic              done_set,
  output logic              drop,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data
);
  localparam int SEL_BIT = ADDR_W - 1;

  logic is_remote;
  logic accept;

  assign is_remote = wr_valid && !wr_addr[SEL_BIT];
  assign accept    = is_remote && wr_done;
  assign drop      = is_remote && !wr_done;
  // completion: the acknowledge toggle has caught up with the request toggle
  assign done_set  = !wr_done && (ack_sync == req_tgl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      wr_done   <= 1'b1;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (accept) begin
      req_tgl   <= ~req_tgl;
      wr_done   <= 1'b0;
      hold_addr <= wr_addr;
      hold_data <= wr_data;
    end else if (done_set) begin
      wr_done   <= 1'b1;
    end
  end
endmodule

// File: rtl/xwt_slow_side.sv
module xwt_slow_side (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  output logic ack_tgl,
  output logic wr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_tgl <= 1'b0;
    else        ack_tgl <= req_sync;
  end

  // request differs from acknowledge for exactly one slow cycle per toggle
  assign wr_en = req_sync ^ ack_tgl;
endmodule

// File: rtl/xwt_csr.sv
module xwt_csr
  import xwt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rmt_rd_data,
  input  logic              wr_done,
  input  logic              done_set,
  input  logic              drop,
  output logic              rd_data_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_raw,
  output logic              irq_mask,
  output logic              busy_err,
  output logic              irq
);
  localparam int SEL_BIT = ADDR_W - 1;

  logic     loc_wr;
  loc_reg_e wr_sel;
  loc_reg_e rd_sel;
  logic     clr_raw;
  logic     clr_err;
  logic [DATA_W-1:0] loc_val;

  assign loc_wr  = wr_valid && wr_addr[SEL_BIT];
  assign wr_sel  = loc_reg_e'(wr_addr[1:0]);
  assign rd_sel  = loc_reg_e'(rd_addr[1:0]);
  assign clr_raw = loc_wr && (wr_sel == LR_RAW) && wr_data[CLR_RAW_BIT];
  assign clr_err = loc_wr && (wr_sel == LR_RAW) && wr_data[CLR_ERR_BIT];
  assign irq     = irq_raw && irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_raw  <= 1'b0;
      irq_mask <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      // a completion event outranks a simultaneous clear
      if (done_set)     irq_raw <= 1'b1;
      else if (clr_raw) irq_raw <= 1'b0;
      if (drop)         busy_err <= 1'b1;
      else if (clr_err) busy_err <= 1'b0;
      if (loc_wr && (wr_sel == LR_MASK)) irq_mask <= wr_data[MASK_BIT];
    end
  end

  always_comb begin
    loc_val = '0;
    unique case (rd_sel)
      LR_STATUS: begin
        loc_val[ST_DONE_BIT] = wr_done;
        loc_val[ST_ERR_BIT]  = busy_err;
      end
      LR_MASK:   loc_val[MASK_BIT]    = irq_mask;
      LR_RAW:    loc_val[CLR_RAW_BIT] = irq_raw;
      LR_MASKED: loc_val[0]           = irq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_data_valid <= rd_valid;
      if (rd_valid) rd_data <= rd_addr[SEL_BIT] ? loc_val : rmt_rd_data;
    end
  end
endmodule

// File: rtl/xwt_tracker.sv
module xwt_tracker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic [ADDR_W-1:0] rmt_rd_addr,
  input  logic [DATA_W-1:0] rmt_rd_data,
  input  logic              slow_clk,
  input  logic              slow_rst_n,
  output logic              slow_wr_en,
  output logic [ADDR_W-1:0] slow_wr_addr,
  output logic [DATA_W-1:0] slow_wr_data
);
  logic req_tgl, req_sync, ack_tgl, ack_sync;
  logic wr_done, done_set, drop;
  logic irq_raw, irq_mask, busy_err;

  assign wr_ready    = 1'b1;
  assign rmt_rd_addr = rd_addr;

  xwt_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_sync(ack_sync), .req_tgl(req_tgl), .wr_done(wr_done),
    .done_set(done_set), .drop(drop),
    .hold_addr(slow_wr_addr), .hold_data(slow_wr_data)
  );

  xwt_sync #(.W(1), .STAGES(SYNC_STGS)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_sync)
  );

  xwt_slow_side u_slow (
    .clk(slow_clk), .rst_n(slow_rst_n), .req_sync(req_sync),
    .ack_tgl(ack_tgl), .wr_en(slow_wr_en)
  );

  xwt_sync #(.W(1), .STAGES(SYNC_STGS)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  xwt_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rmt_rd_data(rmt_rd_data),
    .wr_done(wr_done), .done_set(done_set), .drop(drop),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .irq_raw(irq_raw), .irq_mask(irq_mask), .busy_err(busy_err), .irq(irq)
  );
endmodule

// File: rtl/xwt_chk.sv
module xwt_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              slow_clk,
  input logic              slow_rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_done,
  input logic              raw,
  input logic              err,
  input logic              rd_valid,
  input logic              rd_data_valid,
  input logic              slow_wr_en,
  input logic [ADDR_W-1:0] slow_wr_addr,
  input logic [DATA_W-1:0] slow_wr_data
);
  localparam int SEL_BIT = ADDR_W - 1;

  logic rmt_wr;
  logic err_clr;
  assign rmt_wr  = wr_valid && !wr_addr[SEL_BIT];
  assign err_clr = wr_valid && wr_addr[SEL_BIT] && (wr_addr[1:0] == 2'd2) && wr_data[1];

  // R2
  wr_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rmt_wr && wr_done |=> !wr_done);

  // R3
  hold_stable_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !wr_done && $past(!wr_done) |-> $stable(slow_wr_addr) && $stable(slow_wr_data));

  // R3
  slow_pulse_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    slow_wr_en |=> !slow_wr_en);

  // R4
  raw_on_done_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(wr_done) |-> raw);

  // R7
  drop_err_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rmt_wr && !wr_done |=> err && !wr_done);

  // R6
  err_sticky_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    err && !err_clr |=> err);

  // R8
  rd_lat_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rd_valid |=> rd_data_valid);
endmodule

bind xwt_tracker xwt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_done(wr_done), .raw(irq_raw), .err(busy_err),
  .rd_valid(rd_valid), .rd_data_valid(rd_data_valid),
  .slow_wr_en(slow_wr_en), .slow_wr_addr(slow_wr_addr), .slow_wr_data(slow_wr_data)
);

// File: tb/tb_xwt_tracker.sv
module tb_xwt_tracker;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_STAT = 8'h80, A_MASK = 8'h81, A_RAW = 8'h82, A_MSKD = 8'h83;

  logic bus_clk = 0, slow_clk = 0, bus_rst_n = 0, slow_rst_n = 0;
  logic wr_valid = 0, rd_valid = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_data_valid, irq, slow_wr_en;
  logic [DW-1:0] rd_data, rmt_rd_data, slow_wr_data;
  logic [AW-1:0] rmt_rd_addr, slow_wr_addr;

  int checks = 0, errors = 0, slow_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;

  always #2 bus_clk = ~bus_clk;
  always #15 slow_clk = ~slow_clk;

  assign rmt_rd_data = {24'hA5C3E1, rmt_rd_addr};

  xwt_tracker dut (.*);

  always @(negedge slow_clk) if (slow_wr_en) begin
    slow_cnt++;
    last_addr = slow_wr_addr;
    last_data = slow_wr_data;
  end

  localparam logic [39:0] VEC [6] = '{
    {8'h00, 32'h0000_0001}, {8'h7F, 32'hFFFF_FFFF}, {8'h15, 32'hDEAD_BEEF},
    {8'h2A, 32'h0000_0000}, {8'h40, 32'h8000_0001}, {8'h03, 32'h1234_5678}
  };

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_valid = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge bus_clk);
    rd_valid = 1; rd_addr = a;
    @(negedge bus_clk);
    rd_valid = 0;
    v = rd_data_valid;
    d = rd_data;
  endtask

  task automatic wait_done(output bit ok);
    logic [DW-1:0] d; logic v;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_STAT, d, v);
      if (d[0]) begin ok = 1; break; end
    end
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d; logic v; bit ok; int base;
    repeat (4) @(negedge slow_clk);
    @(negedge bus_clk); bus_rst_n = 1; slow_rst_n = 1;
    repeat (2) @(negedge bus_clk);

    // R1 reset state
    bus_rd(A_STAT, d, v); chk(d == 32'h1, "R1 status", d, 32'h1);
    bus_rd(A_RAW, d, v);  chk(d == 32'h0, "R1 raw", d, 32'h0);
    bus_rd(A_MASK, d, v); chk(d == 32'h0, "R1 mask", d, 32'h0);
    chk(irq == 0 && wr_ready == 1, "R1 irq/ready", {30'b0, irq, wr_ready}, 32'h1);

    // vector table: remote writes
    for (int k = 0; k < 6; k++) begin
      base = slow_cnt;
      bus_wr(VEC[k][39:32], VEC[k][31:0]);
      bus_rd(A_STAT, d, v); chk(d[0] == 0, "R2 done cleared", d, 32'h0);
      bus_rd(8'h10 + 8'(k), d, v);
      chk(v && d == {24'hA5C3E1, 8'h10 + 8'(k)}, "R8 read while busy", d, {24'hA5C3E1, 8'h10 + 8'(k)});
      wait_done(ok); chk(ok, "R4 done returns", {31'b0, ok}, 32'h1);
      chk(slow_cnt == base + 1 && last_addr == VEC[k][39:32] && last_data == VEC[k][31:0],
          "R3 slow strobe", last_data, VEC[k][31:0]);
      bus_rd(A_RAW, d, v); chk(d == 32'h1, "R4 raw set", d, 32'h1);
      chk(irq == 0, "R5 irq masked off", {31'b0, irq}, 32'h0);
      bus_wr(A_RAW, 32'h1);
      bus_rd(A_RAW, d, v); chk(d == 32'h0, "R6 raw cleared", d, 32'h0);
    end

    // R7 write while busy dropped
    base = slow_cnt;
    bus_wr(8'h11, 32'hAAAA_0001);
    bus_wr(8'h22, 32'hBBBB_0002);
    bus_rd(A_STAT, d, v); chk(d == 32'h2, "R7 busy and error", d, 32'h2);
    // R9 local write during busy
    bus_wr(A_MASK, 32'h1);
    wait_done(ok); chk(ok, "R9 done after local write", {31'b0, ok}, 32'h1);
    chk(slow_cnt == base + 1 && last_addr == 8'h11 && last_data == 32'hAAAA_0001,
        "R7 dropped write unseen", last_data, 32'hAAAA_0001);
    repeat (40) @(negedge bus_clk);
    chk(slow_cnt == base + 1, "R7 no late strobe", slow_cnt, base + 1);
    // R5 mask enabled
    chk(irq == 1, "R5 irq asserted", {31'b0, irq}, 32'h1);
    bus_rd(A_MSKD, d, v); chk(d == 32'h1, "R5 masked reg", d, 32'h1);
    // R6 zero write no effect, then error clear alone
    bus_wr(A_RAW, 32'h0);
    bus_rd(A_STAT, d, v); chk(d == 32'h3, "R6 zero write keeps error", d, 32'h3);
    bus_wr(A_RAW, 32'h2);
    bus_rd(A_STAT, d, v); chk(d == 32'h1, "R6 error cleared", d, 32'h1);
    bus_rd(A_RAW, d, v);  chk(d == 32'h1, "R6 raw kept", d, 32'h1);
    bus_wr(A_RAW, 32'h1);
    chk(irq == 0, "R5 irq drops with raw", {31'b0, irq}, 32'h0);
    // R8 back-to-back reads
    @(negedge bus_clk); rd_valid = 1; rd_addr = 8'h05;
    @(negedge bus_clk); rd_addr = 8'h06;
    chk(rd_data_valid && rd_data == {24'hA5C3E1, 8'h05}, "R8 back-to-back 1", rd_data, {24'hA5C3E1, 8'h05});
    @(negedge bus_clk); rd_valid = 0;
    chk(rd_data_valid && rd_data == {24'hA5C3E1, 8'h06}, "R8 back-to-back 2", rd_data, {24'hA5C3E1, 8'h06});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule